// File: doc/BRIEF.md
# Environment-configuration CSR access gate

This block owns the supervisor and hypervisor environment-configuration registers together with three level-0 state-enable registers (machine, hypervisor, supervisor). It also decides, in the same cycle as each request, whether a CSR access from the current privilege level is permitted. Two inputs describe the hart's configuration: whether the state-enable extension is switched on and whether supervisor mode exists. Two more describe the current context: the privilege level and the virtualization flag.

The three state-enable registers form a hierarchy. Each one has an envcfg-group enable bit and a master bit. When an outer register's master bit is clear, the registers inside it count as zero for the permission decision. A denied access leaves every register unchanged and returns zero data. It also reports either an illegal-instruction fault or a virtual-instruction fault. Addresses outside the six handled CSRs read as zero and never fault. Accesses to the state-enable registers themselves are not gated here.

Top module: `envcfg_gate`

## Requirements
- R1: After reset, all six registers read as zero.
- R2: A request made at machine privilege (priv_i = 3) is never faulted. Neither is any request made while ext_en_i is 0.
- R3: For a non-machine request to senvcfg (0x10A), henvcfg (0x60A) or henvcfgh (0x61A), a clear bit 62 in the machine state-enable register (0x30C) gives fault_o = 1 (illegal). This check takes priority over every other check, even when virt_i is 1.
- R4: When bit 63 of the machine state-enable register is clear, the hypervisor register (0x60C) and the supervisor register (0x10C) count as zero for the decision.
- R5: With virt_i = 1, a clear effective hypervisor bit 62 gives fault_o = 2 (virtual instruction). fault_o = 2 never occurs while virt_i is 0.
- R6: With virt_i = 1, a clear effective hypervisor bit 63 makes the supervisor register count as zero.
- R7: At user privilege (priv_i = 0) with smode_i = 1, a clear effective supervisor bit 62 gives fault_o = 1. With smode_i = 0 this check is skipped.
- R8: A write to any state-enable register updates only bits 63 and 62. All other bits read as zero.
- R9: A write to senvcfg updates only bits 0 and 7:4.
- R10: A write to henvcfg updates bits 0 and 7:4. When WIDE_HENV = 1, it also updates bits 63:62.
- R11: henvcfgh reads henvcfg bits 63:32 in its low 32 bits. A write to henvcfgh takes wdata bits 31:30 into henvcfg bits 63:62 and leaves every other bit unchanged.
- R12: fault_o is valid in the same cycle as req_i and is 0 while req_i is 0. A faulted access modifies no register and returns rdata_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization active |
| smode_i | input | 1 | Supervisor mode implemented |
| ext_en_i | input | 1 | State-enable extension switched on |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Request is a write |
| addr_i | input | 12 | CSR address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, zero when idle or faulted |
| fault_o | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |

## Verification
fault_o and rdata_o are combinational, so both are due in the same cycle as the request. A write becomes visible only after the next rising edge. The bench drives each request on the falling edge and samples the outputs 1 ns later, which is well before the rising edge that commits any write. Every stored value is therefore checked by a separate read access issued in a later cycle.

// File: rtl/envcfg_gate_pkg.sv
package envcfg_gate_pkg;
    localparam int DATA_W = 64;
    localparam int LEVELS = 3;
    localparam int LVL_M  = 0;
    localparam int LVL_H  = 1;
    localparam int LVL_S  = 2;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int BIT_MASTER = 63;
    localparam int BIT_GROUP  = 62;

    localparam logic [DATA_W-1:0] LOW_CFG_MASK = 64'h0000_0000_0000_00F1;
    localparam logic [DATA_W-1:0] HI_CFG_MASK  = 64'hC000_0000_0000_0000;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ILLEGAL = 2'd1,
        FLT_VIRTUAL = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENV,
        SEL_HENV,
        SEL_HENVH,
        SEL_MST,
        SEL_HST,
        SEL_SST
    } csr_sel_e;
endpackage

// File: rtl/envcfg_gate_check.sv
module envcfg_gate_check
    import envcfg_gate_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic       smode_i,
    input  logic       ext_en_i,
    input  logic [1:0] m_bits,
    input  logic [1:0] h_bits,
    input  logic [1:0] s_bits,
    output fault_e     verdict
);
    // bit [1] = master, bit [0] = envcfg group
    logic [1:0] h_eff;
    logic [1:0] s_eff;

    always_comb begin
        h_eff = m_bits[1] ? h_bits : 2'b00;
        s_eff = m_bits[1] ? s_bits : 2'b00;
        if (virt_i && !h_eff[1]) begin
            s_eff = 2'b00;
        end
        verdict = FLT_NONE;
        if (priv_i == PRIV_M || !ext_en_i) begin
            verdict = FLT_NONE;
        end else if (!m_bits[0]) begin
            verdict = FLT_ILLEGAL;
        end else if (virt_i && !h_eff[0]) begin
            verdict = FLT_VIRTUAL;
        end else if (priv_i == PRIV_U && smode_i && !s_eff[0]) begin
            verdict = FLT_ILLEGAL;
        end
    end
endmodule

// File: rtl/envcfg_gate_stateen.sv
module envcfg_gate_stateen
    import envcfg_gate_pkg::*;
#(
    parameter int NLVL = LEVELS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NLVL-1:0]              wr_en,
    input  logic [1:0]                   wr_bits,
    output logic [NLVL-1:0][DATA_W-1:0]  st_q
);
    localparam int PAD_W = DATA_W - 2;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        logic [1:0] bits_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q <= 2'b00;
            end else if (wr_en[g]) begin
                bits_q <= wr_bits;
            end
        end
        assign st_q[g] = {bits_q, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/envcfg_gate_cfgregs.sv
module envcfg_gate_cfgregs
    import envcfg_gate_pkg::*;
#(
    parameter bit WIDE_HENV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              senv_we,
    input  logic              henv_we,
    input  logic              henvh_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] senv_q,
    output logic [DATA_W-1:0] henv_q
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] HENV_MASK =
        WIDE_HENV ? (LOW_CFG_MASK | HI_CFG_MASK) : LOW_CFG_MASK;

    logic [DATA_W-1:0] hi_wdata;
    assign hi_wdata = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            senv_q <= '0;
            henv_q <= '0;
        end else begin
            if (senv_we) begin
                senv_q <= (senv_q & ~LOW_CFG_MASK) | (wdata & LOW_CFG_MASK);
            end
            if (henv_we) begin
                henv_q <= (henv_q & ~HENV_MASK) | (wdata & HENV_MASK);
            end else if (henvh_we) begin
                henv_q <= (henv_q & ~HI_CFG_MASK) | (hi_wdata & HI_CFG_MASK);
            end
        end
    end
endmodule

// File: rtl/envcfg_gate.sv
module envcfg_gate
    import envcfg_gate_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter bit          WIDE_HENV  = 1'b1,
    parameter logic [11:0] A_SENV     = 12'h10A,
    parameter logic [11:0] A_HENV     = 12'h60A,
    parameter logic [11:0] A_HENVH    = 12'h61A,
    parameter logic [11:0] A_MST      = 12'h30C,
    parameter logic [11:0] A_HST      = 12'h60C,
    parameter logic [11:0] A_SST      = 12'h10C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              smode_i,
    input  logic              ext_en_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [63:0]       wdata_i,
    output logic [63:0]       rdata_o,
    output logic [1:0]        fault_o
);
    localparam int HALF_W = DATA_W / 2;

    csr_sel_e                      sel;
    fault_e                        verdict;
    fault_e                        fault;
    logic                          is_cfg;
    logic                          ok;
    logic [LEVELS-1:0]             st_we;
    logic [LEVELS-1:0][DATA_W-1:0] st_q;
    logic [DATA_W-1:0]             senv_q;
    logic [DATA_W-1:0]             henv_q;

    always_comb begin
        unique case (addr_i)
            ADDR_W'(A_SENV):  sel = SEL_SENV;
            ADDR_W'(A_HENV):  sel = SEL_HENV;
            ADDR_W'(A_HENVH): sel = SEL_HENVH;
            ADDR_W'(A_MST):   sel = SEL_MST;
            ADDR_W'(A_HST):   sel = SEL_HST;
            ADDR_W'(A_SST):   sel = SEL_SST;
            default:          sel = SEL_NONE;
        endcase
    end

    assign is_cfg = (sel == SEL_SENV) || (sel == SEL_HENV) || (sel == SEL_HENVH);

    envcfg_gate_check u_check (
        .priv_i   (priv_i),
        .virt_i   (virt_i),
        .smode_i  (smode_i),
        .ext_en_i (ext_en_i),
        .m_bits   (st_q[LVL_M][BIT_MASTER:BIT_GROUP]),
        .h_bits   (st_q[LVL_H][BIT_MASTER:BIT_GROUP]),
        .s_bits   (st_q[LVL_S][BIT_MASTER:BIT_GROUP]),
        .verdict  (verdict)
    );

    assign fault   = (req_i && is_cfg) ? verdict : FLT_NONE;
    assign fault_o = fault;
    assign ok      = req_i && (fault == FLT_NONE);

    assign st_we[LVL_M] = ok && we_i && (sel == SEL_MST);
    assign st_we[LVL_H] = ok && we_i && (sel == SEL_HST);
    assign st_we[LVL_S] = ok && we_i && (sel == SEL_SST);

    envcfg_gate_stateen #(.NLVL(LEVELS)) u_stateen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_we),
        .wr_bits (wdata_i[BIT_MASTER:BIT_GROUP]),
        .st_q    (st_q)
    );

    envcfg_gate_cfgregs #(.WIDE_HENV(WIDE_HENV)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .senv_we  (ok && we_i && (sel == SEL_SENV)),
        .henv_we  (ok && we_i && (sel == SEL_HENV)),
        .henvh_we (ok && we_i && (sel == SEL_HENVH)),
        .wdata    (wdata_i),
        .senv_q   (senv_q),
        .henv_q   (henv_q)
    );

    always_comb begin
        rdata_o = '0;
        if (ok) begin
            unique case (sel)
                SEL_SENV:  rdata_o = senv_q;
                SEL_HENV:  rdata_o = henv_q;
                SEL_HENVH: rdata_o = {{HALF_W{1'b0}}, henv_q[DATA_W-1:HALF_W]};
                SEL_MST:   rdata_o = st_q[LVL_M];
                SEL_HST:   rdata_o = st_q[LVL_H];
                SEL_SST:   rdata_o = st_q[LVL_S];
                default:   rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/envcfg_gate_sva.sv
module envcfg_gate_sva (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  priv_i,
    input logic        virt_i,
    input logic        ext_en_i,
    input logic        req_i,
    input logic [11:0] addr_i,
    input logic [63:0] rdata_o,
    input logic [1:0]  fault_o,
    input logic [63:0] mst,
    input logic [63:0] hst,
    input logic [63:0] sst,
    input logic [63:0] senv,
    input logic [63:0] henv
);
    logic cfg_addr;
    assign cfg_addr = (addr_i == 12'h10A) || (addr_i == 12'h60A) || (addr_i == 12'h61A);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> fault_o == 2'd0);

    assert_fault_no_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o != 2'd0 |-> rdata_o == 64'd0);

    assert_fault_no_update_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o != 2'd0 |=> $stable(senv) && $stable(henv) && $stable(mst)
                            && $stable(hst) && $stable(sst));

    assert_machine_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && (priv_i == 2'd3 || !ext_en_i) |-> fault_o == 2'd0);

    assert_virtual_needs_virt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o == 2'd2 |-> virt_i);

    assert_machine_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && cfg_addr && priv_i != 2'd3 && ext_en_i && !mst[62] |-> fault_o == 2'd1);
endmodule

bind envcfg_gate envcfg_gate_sva i_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .priv_i   (priv_i),
    .virt_i   (virt_i),
    .ext_en_i (ext_en_i),
    .req_i    (req_i),
    .addr_i   (addr_i),
    .rdata_o  (rdata_o),
    .fault_o  (fault_o),
    .mst      (st_q[0]),
    .hst      (st_q[1]),
    .sst      (st_q[2]),
    .senv     (senv_q),
    .henv     (henv_q)
);

// File: tb/test_envcfg_gate.sv
module test_envcfg_gate;
    localparam logic [11:0] SENV = 12'h10A, HENV = 12'h60A, HENVH = 12'h61A;
    localparam logic [11:0] MST = 12'h30C, HST = 12'h60C, SST = 12'h10C;
    localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;
    localparam logic [63:0] BOTH = 64'hC000_0000_0000_0000;
    localparam logic [63:0] GRP  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv_i = 2'd3;
    logic        virt_i = 1'b0, smode_i = 1'b1, ext_en_i = 1'b1;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [63:0] wdata_i = '0;
    logic [63:0] rdata_o;
    logic [1:0]  fault_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    envcfg_gate i_envcfg_gate (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .virt_i(virt_i),
        .smode_i(smode_i), .ext_en_i(ext_en_i), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .fault_o(fault_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] p, input logic v, input logic sm, input logic ex,
                       input logic w, input logic [11:0] a, input logic [63:0] wd,
                       output logic [63:0] rd, output logic [1:0] f);
        @(negedge clk);
        priv_i = p; virt_i = v; smode_i = sm; ext_en_i = ex;
        we_i = w; addr_i = a; wdata_i = wd; req_i = 1'b1;
        #1;
        rd = rdata_o;
        f = fault_o;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic mwr(input logic [11:0] a, input logic [63:0] wd);
        logic [63:0] rd; logic [1:0] f;
        acc(PM, 1'b0, 1'b1, 1'b1, 1'b1, a, wd, rd, f);
    endtask

    task automatic mrd(input logic [11:0] a, output logic [63:0] rd);
        logic [1:0] f;
        acc(PM, 1'b0, 1'b1, 1'b1, 1'b0, a, '0, rd, f);
    endtask

    task automatic t_reset;
        logic [63:0] rd;
        mrd(SENV, rd);  chk("R1 senvcfg", rd, 0);
        mrd(HENV, rd);  chk("R1 henvcfg", rd, 0);
        mrd(MST, rd);   chk("R1 mstate", rd, 0);
        mrd(HST, rd);   chk("R1 hstate", rd, 0);
        mrd(SST, rd);   chk("R1 sstate", rd, 0);
        #1; chk("R12 idle fault", {62'd0, fault_o}, 0);
    endtask

    task automatic t_free;
        logic [63:0] rd; logic [1:0] f;
        acc(PS, 1'b1, 1'b1, 1'b0, 1'b0, SENV, '0, rd, f);
        chk("R2 ext off", {62'd0, f}, 0);
        acc(PM, 1'b1, 1'b1, 1'b1, 1'b0, HENV, '0, rd, f);
        chk("R2 machine", {62'd0, f}, 0);
    endtask

    task automatic t_machine_bit;
        logic [63:0] rd; logic [1:0] f;
        mwr(SENV, ONES);
        mwr(HST, BOTH);
        acc(PS, 1'b0, 1'b1, 1'b1, 1'b0, SENV, '0, rd, f);
        chk("R3 S illegal", {62'd0, f}, 1);
        chk("R12 zero data", rd, 0);
        acc(PS, 1'b1, 1'b1, 1'b1, 1'b0, HENV, '0, rd, f);
        chk("R3 priority over virtual", {62'd0, f}, 1);
        acc(PS, 1'b0, 1'b1, 1'b1, 1'b1, SENV, '0, rd, f);
        chk("R12 write fault", {62'd0, f}, 1);
        mrd(SENV, rd);
        chk("R12 no update", rd, 64'hF1);
    endtask

    task automatic t_masks;
        logic [63:0] rd;
        mwr(MST, ONES); mrd(MST, rd); chk("R8 mstate mask", rd, BOTH);
        mwr(SST, ONES); mrd(SST, rd); chk("R8 sstate mask", rd, BOTH);
        mwr(SST, 64'h3FFF_FFFF_FFFF_FFFF); mrd(SST, rd); chk("R8 sstate clear", rd, 0);
        mwr(SENV, 64'h0F0F); mrd(SENV, rd); chk("R9 senvcfg mask", rd, 64'h01);
        mwr(HENV, ONES); mrd(HENV, rd); chk("R10 henvcfg mask", rd, 64'hC000_0000_0000_00F1);
        mrd(HENVH, rd); chk("R11 henvcfgh read", rd, 64'hC000_0000);
        mwr(HENVH, 64'hFFFF_FFFF_4000_0000); mrd(HENV, rd);
        chk("R11 henvcfgh write", rd, 64'h4000_0000_0000_00F1);
    endtask

    task automatic t_master;
        logic [63:0] rd; logic [1:0] f;
        mwr(MST, GRP); mwr(HST, BOTH); mwr(SST, BOTH);
        acc(PS, 1'b1, 1'b1, 1'b1, 1'b0, SENV, '0, rd, f);
        chk("R4 hyp zeroed virtual", {62'd0, f}, 2);
        acc(PS, 1'b0, 1'b1, 1'b1, 1'b0, SENV, '0, rd, f);
        chk("R4 S allowed", {62'd0, f}, 0);
        acc(PU, 1'b0, 1'b1, 1'b1, 1'b0, SENV, '0, rd, f);
        chk("R4 sup zeroed", {62'd0, f}, 1);
    endtask

    task automatic t_user_virt;
        logic [63:0] rd; logic [1:0] f;
        mwr(MST, BOTH); mwr(HST, '0); mwr(SST, BOTH);
        acc(PU, 1'b0, 1'b1, 1'b1, 1'b0, SENV, '0, rd, f);
        chk("R7 U allowed", {62'd0, f}, 0);
        acc(PS, 1'b1, 1'b1, 1'b1, 1'b0, SENV, '0, rd, f);
        chk("R5 virtual", {62'd0, f}, 2);
        mwr(HST, GRP);
        acc(PU, 1'b1, 1'b1, 1'b1, 1'b0, SENV, '0, rd, f);
        chk("R6 sup zeroed", {62'd0, f}, 1);
        mwr(HST, BOTH);
        acc(PU, 1'b1, 1'b1, 1'b1, 1'b0, SENV, '0, rd, f);
        chk("R6 sup kept", {62'd0, f}, 0);
        mwr(SST, '0);
        acc(PU, 1'b0, 1'b1, 1'b1, 1'b0, HENV, '0, rd, f);
        chk("R7 U illegal", {62'd0, f}, 1);
        acc(PU, 1'b0, 1'b0, 1'b1, 1'b0, HENV, '0, rd, f);
        chk("R7 no smode", {62'd0, f}, 0);
        chk("R7 data", rd, 64'h4000_0000_0000_00F1);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_free();
        t_machine_bit();
        t_masks();
        t_master();
        t_user_virt();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule